// File: doc/BRIEF.md
# Memory Tag Check Unit

This block sits in front of a small memory and checks every load or store. It holds a 4-bit allocation tag for each 16-byte granule of a bounded range. It also holds one tagged attribute bit per page. For each access it reads the logical tag from the top byte of the address and compares it with the allocation tag of the addressed granule. It then grants the access, blocks it, or grants it and records the mismatch. The outcome depends on the check mode of the current context and on an override bit.

A store-tag command writes the logical tag of its address into the granule that the address points at. The command is never checked itself. When a page moves from untagged to tagged, every allocation tag in that page is cleared to zero. In synchronous mode a mismatch blocks the access, raises a one-response fault pulse and keeps the full faulting address. In asynchronous mode the access completes, a sticky flag collects the mismatches, and the reported fault address is zero.

Top module: `mem_tag_guard`

## Requirements
- R1: The granule index is address bits [GRAN_W+IDX_W-1:GRAN_W]. A store-tag ignores address bits 3:0, and any byte of a granule sees that granule's tag.
- R2: The logical tag of an access or store-tag is address bits 59:56.
- R3: An access to a page whose tagged attribute is 0 is granted without a fault in every mode. The page index is the top IDX_W-PG_GRAN_W bits of the granule index.
- R4: `ctx_mode` is encoded 0 = ignore, 1 = synchronous, 2 = asynchronous, 3 = reserved. In mode 0 and mode 3 every access is granted and no fault or flag is raised.
- R5: In synchronous mode a tag mismatch gives `rsp_grant`=0 and `sync_fault`=1 in the response one cycle after the request. The same edge loads the full request address into `fault_addr`.
- R6: In asynchronous mode a mismatching access is granted, `async_flag` is set, and `fault_addr` is set to zero.
- R7: When `ctx_tco` is 1, no access is checked, whatever the mode.
- R8: Setting the tagged attribute of an untagged page clears all allocation tags of that page to 0. Setting it again on a page that is already tagged leaves the tags unchanged.
- R9: No logical tag matches everything. Logical tag 0 against a stored nonzero tag is a mismatch.
- R10: `async_flag` stays set until `async_clear` is asserted. If an asynchronous mismatch arrives in the same cycle as the clear, the flag stays set.
- R11: A store-tag request (`req_store_tag`=1) is always granted with no fault. It writes the tag, which later accesses then see.
- R12: After reset all outputs are 0, all tags are 0 and all pages are untagged. `rsp_valid` is 1 exactly one cycle after each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store_tag | input | 1 | 1 = store-tag command, 0 = load/store access |
| req_addr | input | ADDR_W | Request address; bits 59:56 carry the logical tag |
| ctx_mode | input | 2 | Check mode of the current context |
| ctx_tco | input | 1 | Tag check override |
| pg_set_valid | input | 1 | Write the tagged attribute of one page |
| pg_set_idx | input | PG_W | Page to update |
| pg_set_tagged | input | 1 | New tagged attribute value |
| async_clear | input | 1 | Clear the sticky asynchronous flag |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_grant | output | 1 | Access may proceed |
| sync_fault | output | 1 | Synchronous tag fault pulse |
| fault_addr | output | ADDR_W | Last synchronous fault address, or zero after an asynchronous fault |
| async_flag | output | 1 | Sticky asynchronous mismatch flag |

## Verification
Every response output is registered once. The grant, the fault pulse, the fault address and the flag update therefore all appear in the cycle after the request. Tag writes and page updates take effect at the same edge, so they are visible to a request issued in the next cycle. The bench drives each request on a falling edge and samples the results on the following falling edge, which is one rising edge later. This matches the single register stage. It checks `fault_addr` and `async_flag` at that same point to confirm they persist or change as required.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;

    parameter int unsigned TAG_W   = 4;
    parameter int unsigned TAG_LSB = 56;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_SYNC  = 2'd1,
        MODE_ASYNC = 2'd2,
        MODE_RSVD  = 2'd3
    } chk_mode_e;

    typedef struct packed {
        logic rsp_valid;
        logic grant;
        logic sync_fault;
        logic async_flag;
    } rsp_state_t;

endpackage

// File: rtl/tag_array.sv
module tag_array
    import tagchk_pkg::*;
#(
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned PG_GRAN_W = 4,
    localparam int unsigned NUM_GRAN = 1 << IDX_W,
    localparam int unsigned PG_W     = IDX_W - PG_GRAN_W,
    localparam int unsigned NUM_PG   = 1 << PG_W,
    localparam int unsigned PG_GRAN  = 1 << PG_GRAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_page_tagged,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             pg_set_valid,
    input  logic [PG_W-1:0]  pg_set_idx,
    input  logic             pg_set_tagged
);

    logic [TAG_W-1:0] tags_d [NUM_GRAN];
    logic [TAG_W-1:0] tags_q [NUM_GRAN];
    logic [NUM_PG-1:0] pg_d, pg_q;
    logic [NUM_PG-1:0] page_clr;

    // one clear strobe per page: only an untagged->tagged transition clears
    for (genvar p = 0; p < NUM_PG; p++) begin : g_pclr
        assign page_clr[p] = pg_set_valid && pg_set_tagged && !pg_q[p]
                             && (pg_set_idx == PG_W'(p));
    end

    always_comb begin
        tags_d = tags_q;
        pg_d   = pg_q;
        if (wr_en) tags_d[wr_idx] = wr_tag;
        for (int p = 0; p < NUM_PG; p++) begin
            for (int k = 0; k < PG_GRAN; k++) begin
                if (page_clr[p]) tags_d[p*PG_GRAN + k] = '0;
            end
        end
        if (pg_set_valid) pg_d[pg_set_idx] = pg_set_tagged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GRAN; g++) tags_q[g] <= '0;
            pg_q <= '0;
        end else begin
            tags_q <= tags_d;
            pg_q   <= pg_d;
        end
    end

    assign rd_tag         = tags_q[rd_idx];
    assign rd_page_tagged = pg_q[rd_idx[IDX_W-1 -: PG_W]];

    // first granule of a freshly enabled page reads zero after the edge (R8)
    assert_page_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_set_valid && pg_set_tagged && !pg_q[pg_set_idx])
        |=> tags_q[{$past(pg_set_idx), {PG_GRAN_W{1'b0}}}] == '0);

    assert_page_attr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pg_set_valid |=> pg_q[$past(pg_set_idx)] == $past(pg_set_tagged));

endmodule

// File: rtl/tag_judge.sv
module tag_judge
    import tagchk_pkg::*;
(
    input  chk_mode_e        mode,
    input  logic             tco,
    input  logic             page_tagged,
    input  logic             is_store,
    input  logic [TAG_W-1:0] ltag,
    input  logic [TAG_W-1:0] atag,
    output logic             sync_hit,
    output logic             async_hit,
    output logic             grant
);

    logic checking;
    logic mismatch;

    always_comb begin
        checking  = page_tagged && !tco && !is_store
                    && (mode == MODE_SYNC || mode == MODE_ASYNC);
        mismatch  = checking && (ltag != atag);
        sync_hit  = mismatch && (mode == MODE_SYNC);
        async_hit = mismatch && (mode == MODE_ASYNC);
        grant     = !sync_hit;
    end

endmodule

// File: rtl/mem_tag_guard.sv
module mem_tag_guard
    import tagchk_pkg::*;
#(
    parameter int unsigned ADDR_W    = 64,
    parameter int unsigned GRAN_W    = 4,
    parameter int unsigned IDX_W     = 6,
    parameter int unsigned PG_GRAN_W = 4,
    localparam int unsigned PG_W     = IDX_W - PG_GRAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        ctx_mode,
    input  logic              ctx_tco,
    input  logic              pg_set_valid,
    input  logic [PG_W-1:0]   pg_set_idx,
    input  logic              pg_set_tagged,
    input  logic              async_clear,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              sync_fault,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              async_flag
);

    logic [IDX_W-1:0] gidx;
    logic [TAG_W-1:0] ltag;
    logic [TAG_W-1:0] atag;
    logic             page_tagged;
    logic             sync_hit, async_hit, grant;

    rsp_state_t        st_d, st_q;
    logic [ADDR_W-1:0] fa_d, fa_q;

    assign gidx = req_addr[GRAN_W +: IDX_W];
    assign ltag = req_addr[TAG_LSB +: TAG_W];

    tag_array #(.IDX_W(IDX_W), .PG_GRAN_W(PG_GRAN_W)) u_tags (
        .clk            (clk),
        .rst_n          (rst_n),
        .rd_idx         (gidx),
        .rd_tag         (atag),
        .rd_page_tagged (page_tagged),
        .wr_en          (req_valid && req_store_tag),
        .wr_idx         (gidx),
        .wr_tag         (ltag),
        .pg_set_valid   (pg_set_valid),
        .pg_set_idx     (pg_set_idx),
        .pg_set_tagged  (pg_set_tagged)
    );

    tag_judge u_judge (
        .mode        (chk_mode_e'(ctx_mode)),
        .tco         (ctx_tco),
        .page_tagged (page_tagged),
        .is_store    (req_store_tag),
        .ltag        (ltag),
        .atag        (atag),
        .sync_hit    (sync_hit),
        .async_hit   (async_hit),
        .grant       (grant)
    );

    always_comb begin
        st_d            = st_q;
        fa_d            = fa_q;
        st_d.rsp_valid  = req_valid;
        st_d.grant      = req_valid && grant;
        st_d.sync_fault = req_valid && sync_hit;
        if (req_valid && async_hit) begin
            st_d.async_flag = 1'b1;
            fa_d            = '0;
        end else if (async_clear) begin
            st_d.async_flag = 1'b0;
        end
        if (req_valid && sync_hit) fa_d = req_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            fa_q <= '0;
        end else begin
            st_q <= st_d;
            fa_q <= fa_d;
        end
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_grant  = st_q.grant;
    assign sync_fault = st_q.sync_fault;
    assign fault_addr = fa_q;
    assign async_flag = st_q.async_flag;

    assert_sync_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fault |-> (rsp_valid && !rsp_grant));

    assert_sync_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sync_hit) |=> (fault_addr == $past(req_addr) && sync_fault));

    assert_async_noaddr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && async_hit) |=> (async_flag && rsp_grant && fault_addr == '0));

    assert_async_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (async_flag && !async_clear) |=> async_flag);

    assert_ignore_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (ctx_mode == 2'd0 || ctx_mode == 2'd3))
        |=> (rsp_grant && !sync_fault));

    assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ctx_tco) |=> (rsp_grant && !sync_fault));

    assert_store_unchecked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store_tag) |=> (rsp_grant && !sync_fault));

    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

endmodule

// File: tb/sim_mem_tag_guard.sv
module sim_mem_tag_guard;

    localparam int unsigned AW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_store_tag = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    ctx_mode = 2'd0;
    logic          ctx_tco = 1'b0;
    logic          pg_set_valid = 1'b0;
    logic [1:0]    pg_set_idx = '0;
    logic          pg_set_tagged = 1'b0;
    logic          async_clear = 1'b0;
    logic          rsp_valid, rsp_grant, sync_fault, async_flag;
    logic [AW-1:0] fault_addr;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    mem_tag_guard u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store_tag(req_store_tag),
        .req_addr(req_addr), .ctx_mode(ctx_mode), .ctx_tco(ctx_tco),
        .pg_set_valid(pg_set_valid), .pg_set_idx(pg_set_idx), .pg_set_tagged(pg_set_tagged),
        .async_clear(async_clear), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .sync_fault(sync_fault), .fault_addr(fault_addr), .async_flag(async_flag)
    );

    typedef struct packed {
        logic [3:0]    rq;
        logic [1:0]    mode;
        logic          tco;
        logic [AW-1:0] addr;
        logic          grant;
        logic          sflt;
        logic          aflag;
        logic [AW-1:0] fa;
    } vec_t;

    // page 0 tagged, granule 2 holds tag 5, other granules 0; page 1 untagged
    localparam vec_t VEC [10] = '{
        '{4'd2,  2'd1, 1'b0, 64'h0500_0000_0000_0020, 1'b1, 1'b0, 1'b0, 64'h0},                     // R2 match
        '{4'd5,  2'd1, 1'b0, 64'h0300_0000_0000_0024, 1'b0, 1'b1, 1'b0, 64'h0300_0000_0000_0024},   // R5 mismatch
        '{4'd1,  2'd1, 1'b0, 64'h0000_0000_0000_003C, 1'b1, 1'b0, 1'b0, 64'h0300_0000_0000_0024},   // R1 granule 3
        '{4'd9,  2'd1, 1'b0, 64'h0000_0000_0000_0028, 1'b0, 1'b1, 1'b0, 64'h0000_0000_0000_0028},   // R9 tag 0
        '{4'd4,  2'd0, 1'b0, 64'h0300_0000_0000_0020, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0028},   // R4 ignore
        '{4'd4,  2'd3, 1'b0, 64'h0300_0000_0000_0020, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0028},   // R4 reserved
        '{4'd7,  2'd1, 1'b1, 64'h0300_0000_0000_0020, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0028},   // R7 override
        '{4'd3,  2'd1, 1'b0, 64'h0300_0000_0000_0120, 1'b1, 1'b0, 1'b0, 64'h0000_0000_0000_0028},   // R3 untagged
        '{4'd6,  2'd2, 1'b0, 64'h0300_0000_0000_0020, 1'b1, 1'b0, 1'b1, 64'h0},                     // R6 async
        '{4'd10, 2'd2, 1'b0, 64'h0500_0000_0000_0020, 1'b1, 1'b0, 1'b1, 64'h0}                      // R10 sticky
    };

    task automatic check(input string rq, input string what, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // drive one request on a falling edge, sample on the next falling edge
    task automatic req(input logic st, input logic [1:0] m, input logic t,
                       input logic [AW-1:0] a, input logic clr);
        req_valid = 1'b1; req_store_tag = st; ctx_mode = m; ctx_tco = t;
        req_addr = a; async_clear = clr;
        @(negedge clk);
        req_valid = 1'b0; req_store_tag = 1'b0; async_clear = 1'b0;
    endtask

    task automatic page(input logic [1:0] idx, input logic tg);
        pg_set_valid = 1'b1; pg_set_idx = idx; pg_set_tagged = tg;
        @(negedge clk);
        pg_set_valid = 1'b0;
    endtask

    task automatic clear_only();
        async_clear = 1'b1;
        @(negedge clk);
        async_clear = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", "rsp_valid", 64'(rsp_valid), 64'h0);
        check("R12", "rsp_grant", 64'(rsp_grant), 64'h0);
        check("R12", "sync_fault", 64'(sync_fault), 64'h0);
        check("R12", "async_flag", 64'(async_flag), 64'h0);
        check("R12", "fault_addr", fault_addr, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "idle rsp_valid", 64'(rsp_valid), 64'h0);

        page(2'd0, 1'b1);
        // R11: store-tag in synchronous mode with a tag differing from stored 0
        req(1'b1, 2'd1, 1'b0, 64'h0500_0000_0000_002B, 1'b0);
        check("R11", "store rsp_valid", 64'(rsp_valid), 64'h1);
        check("R11", "store grant", 64'(rsp_grant), 64'h1);
        check("R11", "store sync_fault", 64'(sync_fault), 64'h0);

        for (int i = 0; i < 10; i++) begin
            string rq;
            rq = $sformatf("R%0d", VEC[i].rq);
            req(1'b0, VEC[i].mode, VEC[i].tco, VEC[i].addr, 1'b0);
            check(rq, "rsp_valid", 64'(rsp_valid), 64'h1);
            check(rq, "grant", 64'(rsp_grant), 64'(VEC[i].grant));
            check(rq, "sync_fault", 64'(sync_fault), 64'(VEC[i].sflt));
            check(rq, "async_flag", 64'(async_flag), 64'(VEC[i].aflag));
            check(rq, "fault_addr", fault_addr, VEC[i].fa);
        end

        // R5: fault pulse lasts one response
        @(negedge clk);
        check("R5", "pulse gone", 64'(sync_fault), 64'h0);
        // R10: explicit clear
        clear_only();
        check("R10", "cleared", 64'(async_flag), 64'h0);
        // R10: mismatch together with clear keeps flag set
        req(1'b0, 2'd2, 1'b0, 64'h0300_0000_0000_0020, 1'b1);
        check("R10", "priority", 64'(async_flag), 64'h1);
        clear_only();
        check("R10", "cleared again", 64'(async_flag), 64'h0);

        // R1/R11: store tag 9 to granule 5, read at another offset
        req(1'b1, 2'd1, 1'b0, 64'h0900_0000_0000_0050, 1'b0);
        req(1'b0, 2'd1, 1'b0, 64'h0900_0000_0000_005C, 1'b0);
        check("R1", "stored tag seen", 64'(rsp_grant), 64'h1);
        check("R11", "written tag used", 64'(sync_fault), 64'h0);
        // R8: re-enabling an already tagged page keeps tags
        page(2'd0, 1'b1);
        req(1'b0, 2'd1, 1'b0, 64'h0900_0000_0000_0050, 1'b0);
        check("R8", "no clear when tagged", 64'(rsp_grant), 64'h1);
        // R8: untag then tag clears the page
        page(2'd0, 1'b0);
        req(1'b0, 2'd1, 1'b0, 64'h0300_0000_0000_0050, 1'b0);
        check("R3", "untagged page granted", 64'(rsp_grant), 64'h1);
        page(2'd0, 1'b1);
        req(1'b0, 2'd1, 1'b0, 64'h0900_0000_0000_0050, 1'b0);
        check("R8", "old tag gone", 64'(sync_fault), 64'h1);
        check("R5", "fault addr", fault_addr, 64'h0900_0000_0000_0050);
        req(1'b0, 2'd1, 1'b0, 64'h0000_0000_0000_0050, 1'b0);
        check("R8", "cleared to zero", 64'(rsp_grant), 64'h1);
        // R2: bits below 56 inside the top byte region do not form the tag
        req(1'b0, 2'd1, 1'b0, 64'h00FF_FF00_0000_0050, 1'b0);
        check("R2", "only 59:56 used", 64'(rsp_grant), 64'h1);

        finish_run();
    end

endmodule